// File: doc/BRIEF.md
# Program fetch source selector

This block sits between a processor core's instruction-fetch port and two code sources: an on-chip code store and an off-chip program bus. When reset is asserted it samples an external-access strap pin. If the pin is low, every later fetch goes to the off-chip bus. If the pin is high, fetches are served from the on-chip store.

In on-chip mode the store covers addresses 0000h to F7FFh. Any fetch from F800h to FFFFh is answered locally with the opcode 00h, which is a no-operation. Such a fetch never reaches the off-chip bus, so the 2 KB at the top of the map behaves as NOP filler rather than as a spill-over into external memory.

The core raises `fch_req` with `fch_addr` and holds both until the cycle in which `fch_rdy` is high. A new request is accepted only while the block is idle. On-chip and filler fetches complete after a fixed single cycle. Off-chip fetches complete in the cycle in which the bus returns ready.

Top module: `fetch_route`

## Requirements
- R1: If `ea_pin` is 0 in the last reset cycle, every fetch at any address drives `xbus_req` and is completed from the off-chip bus.
- R2: If `ea_pin` is 1 in the last reset cycle, fetches from 0000h–F7FFh are served by the on-chip store with data equal to `imem_rdata`.
- R3: `ea_pin` is sampled only while `rst` is high. Changing it after reset leaves the fetch mode unchanged.
- R4: In on-chip mode, a fetch at or below F7FFh pulses `imem_rd` with `imem_addr` equal to `fch_addr` in the cycle the request is accepted, and `fch_rdy` is high in the following cycle.
- R5: In on-chip mode, a fetch from F800h to FFFFh returns `fch_data` = 00h with `fch_rdy` one cycle after acceptance, and raises neither `imem_rd` nor `xbus_req`.
- R6: In on-chip mode, `xbus_req` is never asserted, including at the boundary address F800h.
- R7: In off-chip mode, `xbus_req` stays high with `xbus_addr` equal to `fch_addr` until `xbus_rdy` is seen. `fch_rdy` rises in that same cycle and carries `xbus_rdata`.
- R8: While `rst` is high and in the first idle cycle after it, `fch_rdy`, `xbus_req` and `imem_rd` are low.
- R9: In off-chip mode, `imem_rd` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap sampling window |
| ea_pin | input | 1 | External-access strap, low selects off-chip fetch |
| fch_req | input | 1 | Fetch request from the core, held until ready |
| fch_addr | input | 16 | Fetch address (program counter) |
| fch_rdy | output | 1 | Fetch complete, data valid |
| fch_data | output | 8 | Fetched opcode byte |
| imem_rd | output | 1 | Read strobe to the on-chip code store |
| imem_addr | output | 16 | On-chip store read address |
| imem_rdata | input | 8 | On-chip store data, valid one cycle after the strobe |
| xbus_req | output | 1 | Off-chip program bus request |
| xbus_addr | output | 16 | Off-chip program bus address |
| xbus_rdata | input | 8 | Off-chip program bus data |
| xbus_rdy | input | 1 | Off-chip program bus ready |

## Verification
The assertions check several rules on every cycle:
- the latched mode holds steady once reset has ended;
- no off-chip request is made in on-chip mode, and no store read in off-chip mode;
- every store read is followed by ready;
- any completed fetch above F7FFh in on-chip mode carries 00h;
- the bus address tracks the held fetch address.

Only the bench's scenarios can show the rest: that the right source is picked at each strap level, the exact data returned at the F7FFh/F800h boundary, the waiting on a slow off-chip ready, and that toggling the strap after reset does nothing.

// File: rtl/fetch_route_pkg.sv
package fetch_route_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam addr_t INT_TOP_DEF = 16'hF7FF;
    localparam word_t NOP_OP_DEF  = 8'h00;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_NOP = 2'd1,
        SRC_EXT = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INT  = 2'd1,
        ST_NOP  = 2'd2,
        ST_EXT  = 2'd3
    } state_e;

    typedef struct packed {
        src_e  src;
        addr_t addr;
    } route_t;

    function automatic src_e pick_src(input logic ext_mode, input addr_t a, input addr_t top);
        if (ext_mode)
            return SRC_EXT;
        else if (a > top)
            return SRC_NOP;
        else
            return SRC_INT;
    endfunction

endpackage

// File: rtl/fetch_mode_latch.sv
module fetch_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic ea_pin,
    output logic ext_mode
);
    // Strap is captured only during reset; held for the rest of operation.
    always_ff @(posedge clk) begin
        if (rst)
            ext_mode <= ~ea_pin;
    end
endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
    import fetch_route_pkg::*;
#(
    parameter addr_t INT_TOP = INT_TOP_DEF
) (
    input  logic   ext_mode,
    input  addr_t  addr,
    output route_t route
);
    always_comb begin
        route.addr = addr;
        route.src  = pick_src(ext_mode, addr, INT_TOP);
    end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_route_pkg::*;
#(
    parameter word_t NOP_OP = NOP_OP_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  route_t route,
    output logic   imem_rd,
    output addr_t  imem_addr,
    input  word_t  imem_rdata,
    output logic   xbus_req,
    output addr_t  xbus_addr,
    input  word_t  xbus_rdata,
    input  logic   xbus_rdy,
    output logic   rdy,
    output word_t  data
);
    state_e state, state_nx;
    addr_t  held_addr;

    wire accept = (state == ST_IDLE) && req;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req) begin
                unique case (route.src)
                    SRC_INT: state_nx = ST_INT;
                    SRC_NOP: state_nx = ST_NOP;
                    default: state_nx = ST_EXT;
                endcase
            end
            ST_INT:  state_nx = ST_IDLE;
            ST_NOP:  state_nx = ST_IDLE;
            ST_EXT:  if (xbus_rdy) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            held_addr <= '0;
        end else begin
            state <= state_nx;
            if (accept)
                held_addr <= route.addr;
        end
    end

    always_comb begin
        imem_rd   = accept && (route.src == SRC_INT);
        imem_addr = route.addr;
        xbus_req  = (state == ST_EXT);
        xbus_addr = held_addr;
        rdy       = 1'b0;
        data      = '0;
        unique case (state)
            ST_INT: begin rdy = 1'b1;     data = imem_rdata; end
            ST_NOP: begin rdy = 1'b1;     data = NOP_OP;     end
            ST_EXT: begin rdy = xbus_rdy; data = xbus_rdy ? xbus_rdata : '0; end
            default: ;
        endcase
    end
endmodule

// File: rtl/fetch_route.sv
module fetch_route
    import fetch_route_pkg::*;
#(
    parameter addr_t INT_TOP = INT_TOP_DEF,
    parameter word_t NOP_OP  = NOP_OP_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ea_pin,
    input  logic              fch_req,
    input  logic [ADDR_W-1:0] fch_addr,
    output logic              fch_rdy,
    output logic [DATA_W-1:0] fch_data,
    output logic              imem_rd,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [DATA_W-1:0] imem_rdata,
    output logic              xbus_req,
    output logic [ADDR_W-1:0] xbus_addr,
    input  logic [DATA_W-1:0] xbus_rdata,
    input  logic              xbus_rdy
);
    logic   ext_mode;
    route_t route;

    fetch_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .ea_pin   (ea_pin),
        .ext_mode (ext_mode)
    );

    fetch_decode #(.INT_TOP(INT_TOP)) u_dec (
        .ext_mode (ext_mode),
        .addr     (fch_addr),
        .route    (route)
    );

    fetch_seq #(.NOP_OP(NOP_OP)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (fch_req),
        .route      (route),
        .imem_rd    (imem_rd),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .xbus_req   (xbus_req),
        .xbus_addr  (xbus_addr),
        .xbus_rdata (xbus_rdata),
        .xbus_rdy   (xbus_rdy),
        .rdy        (fch_rdy),
        .data       (fch_data)
    );
endmodule

// File: rtl/fetch_route_chk.sv
module fetch_route_chk
    import fetch_route_pkg::*;
#(
    parameter addr_t INT_TOP = INT_TOP_DEF,
    parameter word_t NOP_OP  = NOP_OP_DEF
) (
    input logic  clk,
    input logic  rst,
    input logic  ext_mode,
    input addr_t fch_addr,
    input logic  fch_rdy,
    input word_t fch_data,
    input logic  imem_rd,
    input logic  xbus_req,
    input addr_t xbus_addr
);
    // R3: mode does not move once reset has ended
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(ext_mode));

    // R6: on-chip mode never touches the off-chip bus
    p_no_xbus_int_r6: assert property (@(posedge clk) disable iff (rst)
        !ext_mode |-> !xbus_req);

    // R9: off-chip mode never reads the on-chip store
    p_no_imem_ext_r9: assert property (@(posedge clk) disable iff (rst)
        ext_mode |-> !imem_rd);

    // R4: store read is answered next cycle
    p_int_lat_r4: assert property (@(posedge clk) disable iff (rst)
        imem_rd |=> fch_rdy);

    // R5: filler window returns the no-op byte
    p_nop_data_r5: assert property (@(posedge clk) disable iff (rst)
        (fch_rdy && !ext_mode && (fch_addr > INT_TOP)) |-> (fch_data == NOP_OP));

    // R7: bus address follows the held fetch address
    p_xbus_addr_r7: assert property (@(posedge clk) disable iff (rst)
        xbus_req |-> (xbus_addr == fch_addr));

    // R8: nothing active during reset
    always_comb begin
        if (rst) begin
            a_reset_quiet_r8: assert (!fch_rdy && !xbus_req);
        end
    end
endmodule

bind fetch_route fetch_route_chk #(.INT_TOP(INT_TOP), .NOP_OP(NOP_OP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_mode  (ext_mode),
    .fch_addr  (fch_addr),
    .fch_rdy   (fch_rdy),
    .fch_data  (fch_data),
    .imem_rd   (imem_rd),
    .xbus_req  (xbus_req),
    .xbus_addr (xbus_addr)
);

// File: tb/fetch_route_tb.sv
`timescale 1ns/1ps
module fetch_route_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ea_pin = 1'b1;
    logic        fch_req = 1'b0;
    logic [15:0] fch_addr = '0;
    logic        fch_rdy;
    logic [7:0]  fch_data;
    logic        imem_rd;
    logic [15:0] imem_addr;
    logic [7:0]  imem_rdata = '0;
    logic        xbus_req;
    logic [15:0] xbus_addr;
    logic [7:0]  xbus_rdata = '0;
    logic        xbus_rdy = 1'b0;

    int checks = 0;
    int fails  = 0;
    int imem_cnt = 0;
    int xbus_cnt = 0;
    int ext_wait = 2;
    int wcnt = 0;

    always #2.5 clk = ~clk;

    fetch_route u_dut (.*);

    function automatic logic [7:0] int_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] ext_val(input logic [15:0] a);
        return ~(a[7:0] + a[15:8]);
    endfunction

    // on-chip store model: one-cycle read
    always @(posedge clk) begin
        if (imem_rd) begin
            imem_rdata <= int_val(imem_addr);
            imem_cnt   <= imem_cnt + 1;
        end
    end

    // off-chip bus model: ready after ext_wait cycles of request
    always @(posedge clk) begin
        #1;
        if (xbus_req) begin
            xbus_cnt = xbus_cnt + 1;
            wcnt = wcnt + 1;
            if (wcnt >= ext_wait) begin
                xbus_rdy   = 1'b1;
                xbus_rdata = ext_val(xbus_addr);
            end
        end else begin
            wcnt = 0;
            xbus_rdy = 1'b0;
            xbus_rdata = '0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1; ea_pin = pin; fch_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fetch(input logic [15:0] a, output logic [7:0] d, output int cyc);
        @(negedge clk);
        fch_req = 1'b1; fch_addr = a; cyc = 0; d = '0;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (fch_rdy) begin
                d = fch_data;
                break;
            end
        end
        fch_req = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1; ea_pin = 1'b1;
        @(negedge clk);
        check(!fch_rdy && !xbus_req && !imem_rd, "R8 quiet in reset",
              {fch_rdy, xbus_req, imem_rd}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!fch_rdy && !xbus_req && !imem_rd, "R8 quiet after reset",
              {fch_rdy, xbus_req, imem_rd}, 0);
    endtask

    task automatic t_internal();
        logic [15:0] addrs [3] = '{16'h0000, 16'h1234, 16'hF7FF};
        logic [7:0] d; int c; int x0;
        do_reset(1'b1);
        x0 = xbus_cnt;
        foreach (addrs[i]) begin
            fetch(addrs[i], d, c);
            check(d == int_val(addrs[i]), "R2 on-chip data", d, int_val(addrs[i]));
            check(c == 1, "R4 one-cycle latency", c, 1);
        end
        check(xbus_cnt == x0, "R6 no off-chip request", xbus_cnt - x0, 0);
    endtask

    task automatic t_nop_window();
        logic [15:0] addrs [3] = '{16'hF800, 16'hFC00, 16'hFFFF};
        logic [7:0] d; int c; int x0; int m0;
        x0 = xbus_cnt; m0 = imem_cnt;
        foreach (addrs[i]) begin
            fetch(addrs[i], d, c);
            check(d == 8'h00, "R5 filler opcode", d, 0);
            check(c == 1, "R5 filler latency", c, 1);
        end
        check(imem_cnt == m0, "R5 no store read in window", imem_cnt - m0, 0);
        check(xbus_cnt == x0, "R6 no off-chip request at F800h+", xbus_cnt - x0, 0);
    endtask

    task automatic t_strap_late_int();
        logic [7:0] d; int c; int x0;
        @(negedge clk); ea_pin = 1'b0;
        repeat (2) @(negedge clk);
        x0 = xbus_cnt;
        fetch(16'h0100, d, c);
        check(d == int_val(16'h0100), "R3 strap change ignored (on-chip)", d, int_val(16'h0100));
        check(xbus_cnt == x0, "R3 no off-chip after strap change", xbus_cnt - x0, 0);
    endtask

    task automatic t_external();
        logic [15:0] addrs [4] = '{16'h0000, 16'hF7FF, 16'hF800, 16'hFFFF};
        logic [7:0] d; int c; int m0;
        do_reset(1'b0);
        m0 = imem_cnt;
        ext_wait = 3;
        foreach (addrs[i]) begin
            fetch(addrs[i], d, c);
            check(d == ext_val(addrs[i]), "R1 off-chip data", d, ext_val(addrs[i]));
            check(c == 3, "R7 waits for bus ready", c, 3);
        end
        check(imem_cnt == m0, "R9 no store read in off-chip mode", imem_cnt - m0, 0);
        ext_wait = 1;
        fetch(16'h4321, d, c);
        check(d == ext_val(16'h4321) && c == 1, "R7 fast bus ready", d, ext_val(16'h4321));
    endtask

    task automatic t_strap_late_ext();
        logic [7:0] d; int c; int x0;
        @(negedge clk); ea_pin = 1'b1;
        repeat (2) @(negedge clk);
        x0 = xbus_cnt;
        fetch(16'h0200, d, c);
        check(d == ext_val(16'h0200), "R3 strap change ignored (off-chip)", d, ext_val(16'h0200));
        check(xbus_cnt > x0, "R3 still off-chip", xbus_cnt - x0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_internal();
        t_nop_window();
        t_strap_late_int();
        t_external();
        t_strap_late_ext();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule